// File: doc/BRIEF.md
# Segment Table Address Translator

This block converts segmented virtual addresses into physical addresses. A virtual address carries a segment number in its top bits and an offset in the rest. The segment number picks one entry out of a small table. Each entry holds a valid flag, a physical base and a size limit. When the entry is valid and the offset lies below its limit, the result is the base plus the offset. When the entry is invalid, the block reports a segment fault. When the offset is at or past the limit, it reports a limit fault. In both fault cases no physical address is produced.

Software fills the table through a single write port, one entry per cycle. On a context switch, a one-cycle clear pulse invalidates every entry at once. The table can then be reloaded for the next address space. Each result comes back one cycle after its request, with a strobe that marks it.

Top module: `seg_xlate`

## Requirements
- R1: While reset is high, and in the cycle after it falls, all outputs are zero. After reset every table entry is invalid.
- R2: The segment number is virtual address bits [31:28]. The offset is bits [27:0].
- R3: A request to a valid entry whose offset is strictly below the entry's 29-bit limit returns physical address = (base + offset) mod 2^32, with both fault flags low.
- R4: A request to a valid entry whose offset is greater than or equal to its limit raises the limit fault, and the physical address output is zero. A limit of zero faults every offset.
- R5: A request to an invalid entry raises the segment fault with the physical address output at zero. The segment fault takes precedence over any limit check.
- R6: The result strobe is high exactly in the cycle after a request is accepted. In cycles where the strobe is low, the address and both fault flags are zero.
- R7: A table write becomes visible to requests one cycle later. A request in the same cycle as a write to its entry still sees the old contents.
- R8: A clear pulse invalidates all entries. A request in the next cycle to any segment raises the segment fault.
- R9: When a clear and a write happen in the same cycle, the clear wins and the write is discarded.
- R10: A write whose valid bit is 0 invalidates the entry it targets.
- R11: The segment fault and the limit fault are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address: segment [31:28], offset [27:0] |
| wr_en | input | 1 | Table write enable |
| wr_idx | input | 4 | Entry index to write |
| wr_base | input | 32 | Physical base for the entry |
| wr_limit | input | 29 | Segment size in bytes; offsets below it are legal |
| wr_valid | input | 1 | Valid flag stored with the entry |
| clr_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Result strobe, one cycle after req_valid |
| rsp_pa | output | 32 | Physical address, zero on a fault |
| rsp_seg_fault | output | 1 | Entry was invalid |
| rsp_lim_fault | output | 1 | Offset at or beyond the limit |

## Verification
The assertions check on every cycle the timing of the result strobe and the quiet outputs between results. They also check that the two fault flags never rise together and that a fault never comes with a non-zero address. Short write-to-request and clear-to-request patterns are checked the same way: a clear, a write racing a clear, or an invalidating write must leave the next request with a segment fault. The exact physical address, the limit boundary at offset = limit - 1 versus offset = limit, wraparound of base plus offset, and the old-contents rule for a request that meets a write in the same cycle are shown only by the bench. The bench compares each result against its own model of the table.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int VA_W  = 32;
    localparam int SEG_W = 4;
    localparam int OFF_W = VA_W - SEG_W;
    localparam int PA_W  = 32;
    localparam int LIM_W = OFF_W + 1;
    localparam int NSEG  = 1 << SEG_W;

    typedef struct packed {
        logic             valid;
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
    } seg_entry_t;

    typedef enum logic [1:0] {
        XL_IDLE      = 2'd0,
        XL_OK        = 2'd1,
        XL_SEG_FAULT = 2'd2,
        XL_LIM_FAULT = 2'd3
    } xl_status_e;

    typedef struct packed {
        xl_status_e      status;
        logic [PA_W-1:0] pa;
    } xl_result_t;

    function automatic logic [SEG_W-1:0] va_segment(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: SEG_W];
    endfunction

    function automatic logic [OFF_W-1:0] va_offset(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic             clr_all,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);

    seg_entry_t entries [NSEG];

    for (genvar gi = 0; gi < NSEG; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[gi] <= '0;
            end else if (clr_all) begin
                entries[gi].valid <= 1'b0;
            end else if (wr_en && (wr_idx == SEG_W'(gi))) begin
                entries[gi] <= wr_entry;
            end
        end
    end

    always_comb rd_entry = entries[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  logic             active,
    input  seg_entry_t       entry,
    input  logic [OFF_W-1:0] offset,
    output xl_result_t       result
);

    logic             in_range;
    logic [PA_W-1:0]  sum;

    always_comb begin
        in_range = ({1'b0, offset} < entry.limit);
        sum      = entry.base + PA_W'(offset);
        result   = '{status: XL_IDLE, pa: '0};
        if (active) begin
            if (!entry.valid) begin
                result.status = XL_SEG_FAULT;
            end else if (!in_range) begin
                result.status = XL_LIM_FAULT;
            end else begin
                result.status = XL_OK;
                result.pa     = sum;
            end
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    input  logic             wr_valid,
    input  logic             clr_all,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_seg_fault,
    output logic             rsp_lim_fault
);

    seg_entry_t wr_entry;
    seg_entry_t sel_entry;
    xl_result_t comb_res;
    xl_result_t res_q;

    always_comb wr_entry = '{valid: wr_valid, base: wr_base, limit: wr_limit};

    seg_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .clr_all  (clr_all),
        .rd_idx   (va_segment(req_va)),
        .rd_entry (sel_entry)
    );

    seg_check u_check (
        .active (req_valid),
        .entry  (sel_entry),
        .offset (va_offset(req_va)),
        .result (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{status: XL_IDLE, pa: '0};
        end else begin
            res_q <= comb_res;
        end
    end

    always_comb begin
        rsp_valid     = (res_q.status != XL_IDLE);
        rsp_pa        = res_q.pa;
        rsp_seg_fault = (res_q.status == XL_SEG_FAULT);
        rsp_lim_fault = (res_q.status == XL_LIM_FAULT);
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_va,
    input logic             wr_en,
    input logic [SEG_W-1:0] wr_idx,
    input logic             wr_valid,
    input logic             clr_all,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             rsp_seg_fault,
    input logic             rsp_lim_fault
);

    assert_rsp_after_req_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_pa == '0) && !rsp_seg_fault && !rsp_lim_fault);

    assert_single_fault_R11: assert property (@(posedge clk) disable iff (rst)
        !(rsp_seg_fault && rsp_lim_fault));

    assert_lim_fault_no_pa_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_lim_fault |-> (rsp_pa == '0));

    assert_seg_fault_no_pa_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_seg_fault |-> (rsp_pa == '0));

    assert_clear_then_fault_R8: assert property (@(posedge clk) disable iff (rst)
        clr_all ##1 req_valid |=> rsp_seg_fault);

    assert_clear_beats_write_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_all && wr_en) ##1 (req_valid && (req_va[VA_W-1 -: SEG_W] == $past(wr_idx)))
        |=> rsp_seg_fault);

    assert_invalidating_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_valid) ##1 (req_valid && (req_va[VA_W-1 -: SEG_W] == $past(wr_idx)))
        |=> rsp_seg_fault);

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_valid      (wr_valid),
    .clr_all       (clr_all),
    .rsp_valid     (rsp_valid),
    .rsp_pa        (rsp_pa),
    .rsp_seg_fault (rsp_seg_fault),
    .rsp_lim_fault (rsp_lim_fault)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [28:0] wr_limit = '0;
    logic        wr_valid = 1'b0;
    logic        clr_all = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_seg_fault;
    logic        rsp_lim_fault;

    int checks = 0;
    int errors = 0;

    bit          m_valid [16];
    logic [31:0] m_base  [16];
    logic [28:0] m_limit [16];

    always #2.5 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
        .wr_valid(wr_valid), .clr_all(clr_all), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_seg_fault(rsp_seg_fault), .rsp_lim_fault(rsp_lim_fault)
    );

    function automatic logic [34:0] expect_of(input logic rq, input logic [31:0] va);
        logic [3:0]  s = va[31:28];
        logic [27:0] o = va[27:0];
        if (!rq) return {1'b0, 1'b0, 1'b0, 32'h0};
        if (!m_valid[s]) return {1'b1, 1'b1, 1'b0, 32'h0};
        if ({1'b0, o} >= m_limit[s]) return {1'b1, 1'b0, 1'b1, 32'h0};
        return {1'b1, 1'b0, 1'b0, m_base[s] + {4'h0, o}};
    endfunction

    task automatic check_out(input logic [34:0] exp, input string tag);
        logic [34:0] act = {rsp_valid, rsp_seg_fault, rsp_lim_fault, rsp_pa};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual v=%b sf=%b lf=%b pa=%h expected v=%b sf=%b lf=%b pa=%h",
                     tag, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic cycle(input logic rq, input logic [31:0] va,
                         input logic we, input logic [3:0] wi, input logic [31:0] wb,
                         input logic [28:0] wl, input logic wv, input logic clr,
                         input string tag);
        logic [34:0] exp;
        string t;
        req_valid = rq; req_va = va;
        wr_en = we; wr_idx = wi; wr_base = wb; wr_limit = wl; wr_valid = wv;
        clr_all = clr;
        exp = expect_of(rq, va);
        @(posedge clk);
        if (clr) begin
            for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
        end else if (we) begin
            m_valid[wi] = wv; m_base[wi] = wb; m_limit[wi] = wl;
        end
        @(negedge clk);
        t = tag;
        if (t == "") t = !exp[34] ? "R6" : exp[33] ? "R5" : exp[32] ? "R4" : "R3";
        check_out(exp, t);
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] b, input logic [28:0] l, input logic v);
        cycle(1'b0, '0, 1'b1, i, b, l, v, 1'b0, "R6");
    endtask

    task automatic rq(input logic [31:0] va, input string tag);
        cycle(1'b1, va, 1'b0, '0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_base[i] = '0; m_limit[i] = '0;
        end
        repeat (3) @(negedge clk);
        check_out(35'h0, "R1");
        rst = 1'b0;
        @(negedge clk);
        check_out(35'h0, "R1");
        rq(32'h3000_0010, "R1");

        cycle(1'b1, 32'h1000_0000, 1'b1, 4'h1, 32'h4000_0000, 29'h1000, 1'b1, 1'b0, "R7");
        rq(32'h1000_0FFF, "R3");
        rq(32'h1000_1000, "R4");
        rq(32'h1000_0000, "R3");
        cycle(1'b1, 32'h1000_0004, 1'b1, 4'h1, 32'h5000_0000, 29'h10, 1'b1, 1'b0, "R7");
        rq(32'h1000_0004, "R7");

        wr(4'hF, 32'h0000_0010, 29'h1000_0000, 1'b1);
        rq(32'hF0AB_CDEF, "R2");
        rq(32'hFFFF_FFFF, "R2");
        wr(4'h2, 32'hFFFF_FFF0, 29'h100, 1'b1);
        rq(32'h2000_0020, "R3");
        wr(4'h4, 32'h1234_0000, 29'h0, 1'b1);
        rq(32'h4000_0000, "R4");
        wr(4'h1, 32'h4000_0000, 29'h1000, 1'b0);
        rq(32'h1000_0000, "R10");
        cycle(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R6");

        wr(4'h6, 32'h6000_0000, 29'h100, 1'b1);
        cycle(1'b0, '0, 1'b1, 4'h6, 32'h7000_0000, 29'h100, 1'b1, 1'b1, "R9");
        rq(32'h6000_0000, "R9");
        wr(4'h8, 32'h8000_0000, 29'h100, 1'b1);
        rq(32'h8000_0001, "R3");
        cycle(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b1, "R8");
        rq(32'h8000_0001, "R8");
        rq(32'hF000_0000, "R8");

        void'($urandom(32'd4242));
        for (int n = 0; n < 3000; n++) begin
            logic        r  = ($urandom % 4) != 0;
            logic [3:0]  s  = 4'($urandom);
            logic [28:0] t  = m_limit[s] + 29'($urandom % 5) - 29'd2;
            logic [27:0] o  = ($urandom % 2) ? t[27:0] : 28'($urandom);
            logic        we = ($urandom % 4) == 0;
            logic [28:0] wl = ($urandom % 2) ? 29'($urandom) : 29'($urandom % 64);
            logic        cl = ($urandom % 97) == 0;
            cycle(r, {s, o}, we, 4'($urandom), $urandom, wl, ($urandom % 6) != 0, cl, "");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule